// File: doc/BRIEF.md
# Multi-mode self-test register

This block is an n-bit register meant to sit between two combinational blocks. It works as a plain pipeline register in normal operation. For test it becomes one of four things: a serial scan register, a synchronous clear, a maximal-length pseudo-random pattern source, or a parallel-input signature compactor. As a compactor it folds one whole response word into its state every clock. After a test run the final signature is unloaded serially through the scan path. Outside logic then compares it with a known good value.

Two of these registers can be placed around a pair of neighbouring blocks. In one run the first register drives patterns and the second compacts the responses. In the next run the two swap roles, so the block that was the load is now under test. The mode field and the compaction enable are the only controls. The feedback polynomial comes from a built-in table by width, or from a caller-supplied tap mask. A parameter picks the external-XOR or the internal-XOR form of the feedback.

Top module: `mtr_top`

## Requirements
- R1: An active-low reset (`rst_n` = 0) clears every stage to zero at once. `par_out` then reads 0 and `scan_out` reads 0.
- R2: With mode 2'b11 (normal load), the register takes the value of `par_in` at the next rising edge.
- R3: With mode 2'b01 (clear), the register becomes all zeros at the next rising edge. `par_in` and `scan_in` have no effect in this mode.
- R4: With mode 2'b00 (scan), each edge moves every bit one place toward bit W-1, and `scan_in` enters bit 0. `scan_out` always shows bit W-1, so W scan clocks unload the state most significant bit first. `par_in` has no effect in this mode.
- R5: With mode 2'b10 and `comp_en` = 0 (generate), the next state is the current state shifted toward bit W-1, and the XOR of the tapped bits enters bit 0. For W = 4 the taps are bits 3 and 2, which is the polynomial x^4 + x^3 + 1.
- R6: In generate mode, any nonzero start value returns to itself after exactly 2^W - 1 clocks. The state never repeats earlier and never becomes zero.
- R7: With mode 2'b10 and `comp_en` = 1 (compact), the next state is the generate-mode next state XORed bit by bit with `par_in`.
- R8: In compaction, all 2^W signature values can be reached. For W = 4, the 16 values of `par_in` applied to one fixed state give 16 different signatures.
- R9: `comp_en` has no effect in modes 2'b00, 2'b01 and 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 scan, 01 clear, 10 generate/compact, 11 normal load |
| comp_en | input | 1 | In mode 10: 1 selects compaction, 0 selects pattern generation |
| par_in | input | WIDTH | Parallel data or circuit response word |
| scan_in | input | 1 | Serial input into bit 0 |
| par_out | output | WIDTH | Register state |
| scan_out | output | 1 | Serial output, bit WIDTH-1 |

## Verification
A fixed vector sequence moves one register through load, generation, compaction, scan and clear. This shows that each mode picks its own next-state rule and leaves out the inputs it must ignore. Compaction is driven three ways. An all-zero word shows it matches generation. A word equal to the generated state shows it can be driven to zero. A sweep over all sixteen words from one state shows that no two responses give the same signature. A full run from seed 0001 confirms the period of fifteen and that the state never reaches zero. A load followed by four scan clocks confirms the most-significant-first unload order.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

   typedef enum logic [1:0] {
      MODE_SCAN  = 2'b00,
      MODE_CLEAR = 2'b01,
      MODE_LFSR  = 2'b10,
      MODE_LOAD  = 2'b11
   } mtr_mode_e;

   typedef enum int unsigned {
      FB_EXTERNAL = 0,
      FB_INTERNAL = 1
   } mtr_fb_e;

   typedef struct packed {
      logic scan;
      logic clr;
      logic gen;
      logic cmp;
      logic load;
   } mtr_sel_t;

   // Maximal-length taps for widths 2..16; bit k-1 set means term x^k.
   function automatic logic [31:0] mtr_default_taps(input int unsigned w);
      case (w)
         2:       return 32'h0000_0003;
         3:       return 32'h0000_0006;
         4:       return 32'h0000_000C;
         5:       return 32'h0000_0014;
         6:       return 32'h0000_0030;
         7:       return 32'h0000_0060;
         8:       return 32'h0000_00B8;
         9:       return 32'h0000_0110;
         10:      return 32'h0000_0240;
         11:      return 32'h0000_0500;
         12:      return 32'h0000_0829;
         13:      return 32'h0000_100D;
         14:      return 32'h0000_2015;
         15:      return 32'h0000_6000;
         16:      return 32'h0000_D008;
         default: return 32'h0000_0000;
      endcase
   endfunction

endpackage

// File: rtl/mtr_mode_ctrl.sv
module mtr_mode_ctrl
   import mtr_pkg::*;
(
   input  logic [1:0] mode,
   input  logic       comp_en,
   output mtr_sel_t   sel
);
   mtr_mode_e m;

   always_comb begin
      m   = mtr_mode_e'(mode);
      sel = '0;
      unique case (m)
         MODE_SCAN:  sel.scan = 1'b1;
         MODE_CLEAR: sel.clr  = 1'b1;
         MODE_LFSR: begin
            sel.gen = ~comp_en;
            sel.cmp = comp_en;
         end
         MODE_LOAD:  sel.load = 1'b1;
         default:    sel      = '0;
      endcase
   end
endmodule

// File: rtl/mtr_feedback.sv
module mtr_feedback
   import mtr_pkg::*;
#(
   parameter int unsigned WIDTH    = 4,
   parameter logic [WIDTH-1:0] TAPS = 4'hC,
   parameter int unsigned FB_STYLE = FB_EXTERNAL
) (
   input  logic [WIDTH-1:0] state,
   output logic [WIDTH-1:0] step
);
   localparam logic [WIDTH-1:0] INT_MASK = {TAPS[WIDTH-2:0], 1'b1};

   generate
      if (FB_STYLE == FB_EXTERNAL) begin : g_ext
         logic fb;
         always_comb begin
            fb   = ^(state & TAPS);
            step = {state[WIDTH-2:0], fb};
         end
      end else if (FB_STYLE == FB_INTERNAL) begin : g_int
         always_comb begin
            step = {state[WIDTH-2:0], 1'b0} ^ ({WIDTH{state[WIDTH-1]}} & INT_MASK);
         end
      end else begin : g_bad
         $error("mtr_feedback: FB_STYLE must be 0 or 1");
         assign step = state;
      end
   endgenerate
endmodule

// File: rtl/mtr_stage_array.sv
module mtr_stage_array
   import mtr_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  mtr_sel_t         sel,
   input  logic [WIDTH-1:0] par_in,
   input  logic             scan_in,
   input  logic [WIDTH-1:0] step,
   output logic [WIDTH-1:0] q
);
   genvar i;
   generate
      for (i = 0; i < WIDTH; i++) begin : g_stage
         logic shift_src;
         logic d;

         if (i == 0) begin : g_head
            assign shift_src = scan_in;
         end else begin : g_body
            assign shift_src = q[i-1];
         end

         always_comb begin
            d = q[i];
            if (sel.scan)      d = shift_src;
            else if (sel.clr)  d = 1'b0;
            else if (sel.gen)  d = step[i];
            else if (sel.cmp)  d = step[i] ^ par_in[i];
            else if (sel.load) d = par_in[i];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= d;
         end
      end
   endgenerate
endmodule

// File: rtl/mtr_top.sv
module mtr_top
   import mtr_pkg::*;
#(
   parameter int unsigned WIDTH    = 4,
   parameter logic [31:0] TAP_MASK = 32'h0,
   parameter int unsigned FB_STYLE = FB_EXTERNAL
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic             comp_en,
   input  logic [WIDTH-1:0] par_in,
   input  logic             scan_in,
   output logic [WIDTH-1:0] par_out,
   output logic             scan_out
);
   localparam logic [31:0]      TAPS32 = (TAP_MASK != 32'h0) ? TAP_MASK
                                                             : mtr_default_taps(WIDTH);
   localparam logic [WIDTH-1:0] TAPS   = TAPS32[WIDTH-1:0];

   generate
      if (WIDTH < 2 || WIDTH > 32) begin : g_chk_width
         $error("mtr_top: WIDTH must lie in 2..32");
      end
      if (TAPS[WIDTH-1] != 1'b1) begin : g_chk_taps
         $error("mtr_top: tap mask must include the top stage");
      end
   endgenerate

   mtr_sel_t         sel;
   logic [WIDTH-1:0] step;
   logic [WIDTH-1:0] q;

   mtr_mode_ctrl u_ctrl (
      .mode    (mode),
      .comp_en (comp_en),
      .sel     (sel)
   );

   mtr_feedback #(
      .WIDTH    (WIDTH),
      .TAPS     (TAPS),
      .FB_STYLE (FB_STYLE)
   ) u_fb (
      .state (q),
      .step  (step)
   );

   mtr_stage_array #(
      .WIDTH (WIDTH)
   ) u_stages (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel),
      .par_in  (par_in),
      .scan_in (scan_in),
      .step    (step),
      .q       (q)
   );

   assign par_out  = q;
   assign scan_out = q[WIDTH-1];
endmodule

// File: rtl/mtr_checker.sv
module mtr_checker #(
   parameter int unsigned WIDTH = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode,
   input logic             comp_en,
   input logic [WIDTH-1:0] par_in,
   input logic             scan_in,
   input logic [WIDTH-1:0] par_out,
   input logic             scan_out
);
   AST_LOAD_TAKES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11) |=> (par_out == $past(par_in)));                    // R2

   AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01) |=> (par_out == '0));                               // R3

   AST_SCAN_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |=> (par_out == {$past(par_out[WIDTH-2:0]), $past(scan_in)})); // R4

   AST_SERIAL_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      scan_out == par_out[WIDTH-1]);                                      // R4

   AST_GEN_NO_LOCKUP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && !comp_en && par_out != '0) |=> (par_out != '0)); // R6

   AST_CMP_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && comp_en && par_in == '0 && par_out != '0) |=> (par_out != '0)); // R7
endmodule

bind mtr_top mtr_checker #(.WIDTH(WIDTH)) u_mtr_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode     (mode),
   .comp_en  (comp_en),
   .par_in   (par_in),
   .scan_in  (scan_in),
   .par_out  (par_out),
   .scan_out (scan_out)
);

// File: tb/tb_mtr_top.sv
module tb_mtr_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'b01;
   logic       comp_en = 1'b0;
   logic [3:0] par_in = 4'h0;
   logic       scan_in = 1'b0;
   logic [3:0] par_out;
   logic       scan_out;
   int         n_run = 0;
   int         n_fail = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   mtr_top #(.WIDTH(4)) dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .comp_en(comp_en),
      .par_in(par_in), .scan_in(scan_in), .par_out(par_out), .scan_out(scan_out)
   );

   // {mode, comp_en, par_in, scan_in, expected state}
   localparam logic [11:0] VEC [13] = '{
      {2'b11, 1'b0, 4'b1001, 1'b0, 4'b1001},
      {2'b10, 1'b0, 4'b0000, 1'b0, 4'b0011},
      {2'b10, 1'b0, 4'b1111, 1'b0, 4'b0110},
      {2'b10, 1'b0, 4'b0000, 1'b0, 4'b1101},
      {2'b10, 1'b0, 4'b0000, 1'b0, 4'b1010},
      {2'b10, 1'b1, 4'b0101, 1'b0, 4'b0000},
      {2'b10, 1'b1, 4'b0000, 1'b0, 4'b0000},
      {2'b10, 1'b1, 4'b1111, 1'b0, 4'b1111},
      {2'b00, 1'b1, 4'b1010, 1'b0, 4'b1110},
      {2'b00, 1'b0, 4'b0000, 1'b1, 4'b1101},
      {2'b01, 1'b1, 4'b1111, 1'b1, 4'b0000},
      {2'b11, 1'b1, 4'b0110, 1'b0, 4'b0110},
      {2'b10, 1'b1, 4'b0011, 1'b0, 4'b1110}
   };

   function automatic string tag_of(input logic [1:0] m, input logic c);
      case (m)
         2'b00:   return "R4/R9";
         2'b01:   return "R3/R9";
         2'b11:   return "R2/R9";
         default: return c ? "R7" : "R5";
      endcase
   endfunction

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic step(input logic [1:0] m, input logic c, input logic [3:0] d, input logic s);
      @(negedge clk);
      mode = m; comp_en = c; par_in = d; scan_in = s;
      @(posedge clk);
      #1;
   endtask

   task automatic wrap_up();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         wrap_up();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset state", par_out, 4'b0000);
      check("R1 reset scan_out", {3'b000, scan_out}, 4'b0000);
      @(negedge clk);
      rst_n = 1'b1;

      // vector table
      for (int k = 0; k < 13; k++) begin
         step(VEC[k][11:10], VEC[k][9], VEC[k][8:5], VEC[k][4]);
         check(tag_of(VEC[k][11:10], VEC[k][9]), par_out, VEC[k][3:0]);
         check("R4 scan_out tracks top bit", {3'b000, scan_out}, {3'b000, VEC[k][3]});
      end

      // R6: period from seed 0001
      begin
         logic [15:0] seen;
         logic [3:0]  exp_q;
         int          early;
         seen  = '0;
         early = 0;
         step(2'b11, 1'b0, 4'b0001, 1'b0);
         exp_q = 4'b0001;
         for (int k = 1; k <= 15; k++) begin
            step(2'b10, 1'b0, 4'b0000, 1'b0);
            exp_q = {exp_q[2:0], exp_q[3] ^ exp_q[2]};
            check("R5 generate step", par_out, exp_q);
            if (k < 15 && (seen[par_out] || par_out == 4'b0001)) early++;
            seen[par_out] = 1'b1;
         end
         check("R6 returns to seed after 15", par_out, 4'b0001);
         check("R6 no early repeat", early[3:0], 4'd0);
         check("R6 zero never reached", {3'b000, seen[0]}, 4'b0000);
      end

      // R8: all 16 signatures reachable from state 1010
      begin
         logic [15:0] hit;
         hit = '0;
         for (int d = 0; d < 16; d++) begin
            step(2'b11, 1'b0, 4'b1010, 1'b0);
            step(2'b10, 1'b1, 4'(d), 1'b0);
            check("R7 compaction word", par_out, 4'b0101 ^ 4'(d));
            hit[par_out] = 1'b1;
         end
         check("R8 all signatures hit", hit[3:0], 4'hF);
         check("R8 all signatures hit (upper)", hit[15:12], 4'hF);
         check("R8 count of signatures", 4'($countones(hit[14:0])), 4'd15);
      end

      // R4: unload 1011 msb first
      begin
         logic [3:0] got;
         step(2'b11, 1'b0, 4'b1011, 1'b0);
         for (int k = 3; k >= 0; k--) begin
            got[k] = scan_out;
            step(2'b00, 1'b0, 4'b0000, 1'b0);
         end
         check("R4 serial unload order", got, 4'b1011);
         check("R4 state after unload", par_out, 4'b0000);
      end

      // R1: reset in mid run
      step(2'b11, 1'b0, 4'b0111, 1'b0);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 asynchronous reset", par_out, 4'b0000);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      wrap_up();
   end
endmodule